// File: doc/BRIEF.md
# Set/Clear GPIO Port

This block is a general-purpose I/O port of up to 32 lines behind a plain 32-bit register bus. Each access takes one cycle. Software changes the output levels and the output enables through separate write-one-to-set and write-one-to-clear addresses. Because of this, no read-modify-write sequence is needed and concurrent agents cannot lose each other's updates. The direction state can be read back at its own read-only address. A second read-only address returns the sampled pad levels.

Every pad input passes through a two-stage synchroniser. Each line can then be routed through a stability filter. The filter is switched on and off per line through its own set/clear address pair. When it is on, a line changes its reported level only after the synchronised level has differed from the reported one for a number of consecutive prescaled ticks. When it is off, the synchronised level passes straight through.

Top module: `gpio_setclr_port`

## Requirements
- R1: After reset, the output value register, the direction register, the filter-enable register and `rdata_o` are all 0. Every line is therefore an input, with `pad_oe_o` = 0 and `pad_out_o` = 0.
- R2: A write to byte offset 0x000 sets the output value bits where `wdata_i` is 1 and leaves the other bits unchanged. `pad_out_o` shows the new value from the clock edge that accepts the write. `pad_out_o` changes only on writes to 0x000 or 0x004.
- R3: A write to offset 0x004 clears the output value bits where `wdata_i` is 1 and leaves the other bits unchanged.
- R4: A write to offset 0x010 sets direction bits, and a write to offset 0x014 clears them. Both use write-one semantics. A direction bit of 1 makes the line an output, and `pad_oe_o` carries the direction register.
- R5: A read (`req_i`=1, `we_i`=0) of offset 0x018 returns the direction register in bits [NUM_LINES-1:0] on `rdata_o` after the accepting edge. `rdata_o` holds its value until the next read.
- R6: A read of offset 0x080 returns the filtered input levels. A pad change is first visible to a read accepted on the third rising edge after the change. Reads on the first two edges still return the old level.
- R7: A write to offset 0x060 enables the filter for lines whose `wdata_i` bit is 1. A write to offset 0x064 disables it for those lines.
- R8: On a line with the filter on, the reported level takes a new synchronised level only after that level has persisted across DB_COUNT ticks. A tick occurs once every DB_PRESCALE clocks. A pulse shorter than DB_PRESCALE+1 clocks never reaches the reported level when DB_COUNT is 3 or more.
- R9: On a line with the filter off, the synchronised level is reported without further delay.
- R10: Reads of the write-only offsets (0x000, 0x004, 0x010, 0x014, 0x060, 0x064), of unmapped offsets and of offsets that are not a multiple of 4 return 0. Writes to any offset other than the six write offsets change no state.
- R11: With NUM_LINES below 32, read bits [31:NUM_LINES] are 0, and write data bits at or above NUM_LINES are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the access |
| wdata_i | input | 32 | Write data, one bit per line |
| rdata_o | output | 32 | Read data, valid after the accepting edge |
| pad_in_i | input | NUM_LINES | Asynchronous pad input levels |
| pad_out_o | output | NUM_LINES | Pad output values |
| pad_oe_o | output | NUM_LINES | Pad output enables, 1 = drive |

## Verification
The bench builds the port with NUM_LINES = 24, DB_PRESCALE = 2 and DB_COUNT = 4. The narrower port makes the unused upper read bits and the ignored upper write-data bits observable. The short filter window lets the bench place reads precisely around the earliest and latest edges at which a filtered line may change. It also lets the bench show that a 3-cycle glitch is swallowed while an unfiltered neighbour follows the same edge after only the synchroniser delay.

// File: rtl/gpio_setclr_pkg.sv
package gpio_setclr_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 8;

  // offsets are the software contract; kept fixed
  localparam logic [ADDR_W-1:0] OFS_DOUT_SET = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DOUT_CLR = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DIR_SET  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_DIR_CLR  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_DIR_RD   = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_FLT_SET  = 8'h60;
  localparam logic [ADDR_W-1:0] OFS_FLT_CLR  = 8'h64;
  localparam logic [ADDR_W-1:0] OFS_PIN_RD   = 8'h80;

  typedef enum logic [2:0] {
    WR_NONE,
    WR_DOUT_SET,
    WR_DOUT_CLR,
    WR_DIR_SET,
    WR_DIR_CLR,
    WR_FLT_SET,
    WR_FLT_CLR
  } wr_op_e;

  function automatic wr_op_e decode_wr(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_DOUT_SET: decode_wr = WR_DOUT_SET;
      OFS_DOUT_CLR: decode_wr = WR_DOUT_CLR;
      OFS_DIR_SET:  decode_wr = WR_DIR_SET;
      OFS_DIR_CLR:  decode_wr = WR_DIR_CLR;
      OFS_FLT_SET:  decode_wr = WR_FLT_SET;
      OFS_FLT_CLR:  decode_wr = WR_FLT_CLR;
      default:      decode_wr = WR_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce #(
  parameter int unsigned W           = 32,
  parameter int unsigned DB_PRESCALE = 16,
  parameter int unsigned DB_COUNT    = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] lvl_o
);
  localparam int unsigned PRE_W = (DB_PRESCALE > 1) ? $clog2(DB_PRESCALE) : 1;
  localparam int unsigned CNT_W = (DB_COUNT > 1) ? $clog2(DB_COUNT) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DB_PRESCALE - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DB_COUNT - 1);

  logic [PRE_W-1:0] pre_q;
  logic             tick;

  assign tick = (pre_q == PRE_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pre_q <= '0;
    else if (tick) pre_q <= '0;
    else           pre_q <= pre_q + 1'b1;
  end

  logic [W-1:0] filt_q;

  for (genvar i = 0; i < W; i++) begin : g_line
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q     <= '0;
        filt_q[i] <= 1'b0;
      end else if (!en_i[i]) begin
        // track while bypassed so enabling causes no step
        cnt_q     <= '0;
        filt_q[i] <= lvl_i[i];
      end else if (lvl_i[i] == filt_q[i]) begin
        cnt_q <= '0;
      end else if (tick) begin
        if (cnt_q == CNT_LAST) begin
          cnt_q     <= '0;
          filt_q[i] <= lvl_i[i];
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end

    assign lvl_o[i] = en_i[i] ? filt_q[i] : lvl_i[i];
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_setclr_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [W-1:0]      pin_lvl_i,
  output logic [W-1:0]      dout_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      flt_en_o
);
  logic [W-1:0] dout_q, dir_q, flt_q;
  logic [W-1:0] wbits;
  wr_op_e       op;
  logic [BUS_W-1:0] rd_val;

  assign wbits = wdata_i[W-1:0];
  assign op    = (req_i && we_i) ? decode_wr(addr_i) : WR_NONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      dir_q  <= '0;
      flt_q  <= '0;
    end else begin
      case (op)
        WR_DOUT_SET: dout_q <= dout_q | wbits;
        WR_DOUT_CLR: dout_q <= dout_q & ~wbits;
        WR_DIR_SET:  dir_q  <= dir_q | wbits;
        WR_DIR_CLR:  dir_q  <= dir_q & ~wbits;
        WR_FLT_SET:  flt_q  <= flt_q | wbits;
        WR_FLT_CLR:  flt_q  <= flt_q & ~wbits;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      OFS_DIR_RD: rd_val = BUS_W'(dir_q);
      OFS_PIN_RD: rd_val = BUS_W'(pin_lvl_i);
      default:    rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_o <= '0;
    else if (req_i && !we_i)  rdata_o <= rd_val;
  end

  assign dout_o   = dout_q;
  assign dir_o    = dir_q;
  assign flt_en_o = flt_q;
endmodule

// File: rtl/gpio_setclr_port.sv
module gpio_setclr_port
  import gpio_setclr_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 32,
  parameter int unsigned DB_PRESCALE = 16,
  parameter int unsigned DB_COUNT    = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BUS_W-1:0]     wdata_i,
  output logic [BUS_W-1:0]     rdata_o,
  input  logic [NUM_LINES-1:0] pad_in_i,
  output logic [NUM_LINES-1:0] pad_out_o,
  output logic [NUM_LINES-1:0] pad_oe_o
);
  logic [NUM_LINES-1:0] sync_lvl, filt_lvl, flt_en;

  gpio_sync #(.W(NUM_LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (sync_lvl)
  );

  gpio_debounce #(
    .W           (NUM_LINES),
    .DB_PRESCALE (DB_PRESCALE),
    .DB_COUNT    (DB_COUNT)
  ) u_flt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (flt_en),
    .lvl_i  (sync_lvl),
    .lvl_o  (filt_lvl)
  );

  gpio_regs #(.W(NUM_LINES)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .rdata_o   (rdata_o),
    .pin_lvl_i (filt_lvl),
    .dout_o    (pad_out_o),
    .dir_o     (pad_oe_o),
    .flt_en_o  (flt_en)
  );
endmodule

// File: rtl/gpio_setclr_port_chk.sv
module gpio_setclr_port_chk
  import gpio_setclr_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 req_i,
  input logic                 we_i,
  input logic [ADDR_W-1:0]    addr_i,
  input logic [BUS_W-1:0]     wdata_i,
  input logic [BUS_W-1:0]     rdata_o,
  input logic [NUM_LINES-1:0] pad_out_o,
  input logic [NUM_LINES-1:0] pad_oe_o
);
  logic wr, rd;
  logic [NUM_LINES-1:0] wb;
  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;
  assign wb = wdata_i[NUM_LINES-1:0];

  a_r2_dout_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_DOUT_SET) |=> pad_out_o == ($past(pad_out_o) | $past(wb)));

  a_r3_dout_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_DOUT_CLR) |=> pad_out_o == ($past(pad_out_o) & ~$past(wb)));

  a_r2_dout_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr && (addr_i == OFS_DOUT_SET || addr_i == OFS_DOUT_CLR)) |=> $stable(pad_out_o));

  a_r4_dir_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_DIR_SET) |=> pad_oe_o == ($past(pad_oe_o) | $past(wb)));

  a_r4_dir_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_DIR_CLR) |=> pad_oe_o == ($past(pad_oe_o) & ~$past(wb)));

  a_r5_dir_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && addr_i == OFS_DIR_RD) |=> rdata_o == BUS_W'($past(pad_oe_o)));

  a_r10_wo_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && (addr_i == OFS_DOUT_SET || addr_i == OFS_DOUT_CLR || addr_i == OFS_DIR_SET ||
            addr_i == OFS_DIR_CLR || addr_i == OFS_FLT_SET || addr_i == OFS_FLT_CLR))
    |=> rdata_o == '0);
endmodule

bind gpio_setclr_port gpio_setclr_port_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .pad_out_o (pad_out_o),
  .pad_oe_o  (pad_oe_o)
);

// File: tb/gpio_setclr_port_test.sv
`timescale 1ns/1ps
module gpio_setclr_port_test;
  localparam int unsigned NL = 24;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [NL-1:0] pad_in_i = '0;
  logic [NL-1:0] pad_out_o, pad_oe_o;

  always #4 clk_i = ~clk_i;

  gpio_setclr_port #(.NUM_LINES(NL), .DB_PRESCALE(2), .DB_COUNT(4)) uut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .pad_in_i, .pad_out_o, .pad_oe_o
  );

  typedef struct { string tag; logic [31:0] exp; } exp_t;
  exp_t sb_q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;
  logic rd_fire = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: compare read data against the scoreboard
  always @(posedge clk_i) rd_fire <= req_i && !we_i;
  always @(negedge clk_i) begin
    if (rd_fire) begin
      if (sb_q.size() == 0) check("SB_EMPTY", 32'h1, 32'h0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, rdata_o, e.exp);
      end
    end
  end

  // tasks start and end at a falling edge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.tag = tag; e.exp = exp;
    sb_q.push_back(e);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1 out", 32'(pad_out_o), 32'h0);
    check("R1 oe", 32'(pad_oe_o), 32'h0);
    check("R1 rdata", rdata_o, 32'h0);
    rst_ni = 1'b1;
    idle(1);
    bus_read(8'h18, 32'h0, "R1 dir after reset");

    bus_write(8'h00, 32'h0000_00A5);
    check("R2 set", 32'(pad_out_o), 32'h0000_00A5);
    bus_write(8'h00, 32'h0000_0F00);
    check("R2 set keeps", 32'(pad_out_o), 32'h0000_0FA5);
    bus_write(8'h04, 32'h0000_0081);
    check("R3 clr", 32'(pad_out_o), 32'h0000_0F24);

    bus_write(8'h10, 32'h0000_F0F0);
    check("R4 dir set", 32'(pad_oe_o), 32'h0000_F0F0);
    bus_write(8'h14, 32'h0000_0030);
    check("R4 dir clr", 32'(pad_oe_o), 32'h0000_F0C0);
    bus_read(8'h18, 32'h0000_F0C0, "R5 dir read");

    bus_read(8'h00, 32'h0, "R10 wo dout set");
    bus_read(8'h14, 32'h0, "R10 wo dir clr");
    bus_read(8'h60, 32'h0, "R10 wo flt set");
    bus_read(8'h44, 32'h0, "R10 unmapped");
    bus_read(8'h1A, 32'h0, "R10 misaligned read");
    bus_write(8'h18, 32'hFFFF_FFFF);
    check("R10 ro write", 32'(pad_oe_o), 32'h0000_F0C0);
    bus_write(8'h01, 32'hFFFF_FFFF);
    check("R10 misaligned write", 32'(pad_out_o), 32'h0000_0F24);
    bus_write(8'hFC, 32'hFFFF_FFFF);
    check("R10 unmapped write", 32'(pad_out_o), 32'h0000_0F24);

    // R6 synchroniser latency
    pad_in_i = 24'h000003;
    bus_read(8'h80, 32'h0, "R6 edge1 old");
    bus_read(8'h80, 32'h0, "R6 edge2 old");
    bus_read(8'h80, 32'h3, "R6 edge3 new");
    pad_in_i = '0;
    idle(4);

    // R7/R8/R9 filter on line 5, line 6 unfiltered
    bus_write(8'h60, 32'h0000_0020);
    idle(4);
    pad_in_i = 24'h000060;
    idle(3);
    bus_read(8'h80, 32'h40, "R8 held off R9 passes");
    idle(8);
    bus_read(8'h80, 32'h60, "R8 settled");
    pad_in_i = 24'h000060 & ~24'h000020;
    idle(3);
    pad_in_i = 24'h000060;
    idle(12);
    bus_read(8'h80, 32'h60, "R8 glitch swallowed");
    bus_write(8'h64, 32'h0000_0020);
    pad_in_i = 24'h000040;
    idle(2);
    bus_read(8'h80, 32'h40, "R7 filter cleared");

    // R11 narrow port
    pad_in_i = '1;
    idle(3);
    bus_read(8'h80, 32'h00FF_FFFF, "R11 upper read zero");
    bus_write(8'h00, 32'hFFFF_FFFF);
    check("R11 upper write ignored", 32'(pad_out_o), 32'h00FF_FFFF);

    idle(3);
    check("SB drained", 32'(sb_q.size()), 32'h0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule